// File: doc/BRIEF.md
# Partial-Bank Refresh Mode Selector

This block sits in a memory controller's refresh path. For each row set that is due for a refresh, it receives an 8-bit mask. Each bit marks a bank whose rows in that set include a weak, short-retention row. The block works out which refresh granularity covers exactly those banks for the least total refresh busy time. It then streams out the commands that make up that refresh.

Four granularities are available: the whole rank, one half of the banks, one quarter of the banks, and a single bank. Each has its own fixed-point busy-time weight. The cost of a granularity is its weight multiplied by the number of its bank groups that hold at least one weak bank. The cheapest granularity wins.

Each emitted command carries a two-bit mode code and a group index; both travel on address bits next to the refresh command. It also carries a fine-granularity flag, which the block never raises for single-bank commands. Commands leave over a valid/ready handshake, and a one-cycle done pulse closes every row set. A row set with no weak bank yields no command at all, only the done pulse.

Top module: `rfs_mode_select`

## Requirements
- R1: While reset is held, and after release until the first start, `cmd_valid_o` and `done_o` are 0.
- R2: Costs use the weights 1000 (whole rank), 758 (half), 575 (quarter) and 435 (single bank). The cost of a mode is its weight times the number of occupied groups: halves are banks 0-3 and 4-7, and quarters are bank pairs {0,1}, {2,3}, {4,5} and {6,7}. The lowest-cost mode is chosen, and on equal cost the coarser mode wins.
- R3: `cmd_mode_o` encodes 00 whole rank, 01 half, 10 quarter and 11 single bank. `cmd_sel_o` holds the half, quarter or bank index, and is 0 for a whole-rank command.
- R4: A row set yields one command for each occupied group of the chosen mode, in ascending index order, all with the same mode. Together the commands cover every weak bank, and each command covers at least one weak bank.
- R5: An all-zero mask yields no command and a single `done_o` pulse.
- R6: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the command is held and its mode and index stay unchanged.
- R7: `done_o` is high for exactly one cycle, the cycle after the last command is accepted, and never together with `cmd_valid_o`.
- R8: `start_i` is ignored until the running row set has reached `done_o`. A mask offered in that time has no effect on the commands.
- R9: `cmd_fine_o` equals the `fine_gran_i` value captured at start for whole-rank, half and quarter commands, and is 0 for single-bank commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Offer a new row set (taken only when idle) |
| weak_mask_i | input | 8 | One bit per bank holding weak rows in the row set |
| fine_gran_i | input | 1 | Request 2x-granularity refresh for this row set |
| cmd_valid_o | output | 1 | A refresh command is offered |
| cmd_ready_i | input | 1 | Command consumer accepts the offered command |
| cmd_mode_o | output | 2 | Refresh granularity code |
| cmd_sel_o | output | 3 | Half, quarter or bank index |
| cmd_fine_o | output | 1 | 2x-granularity flag for the command |
| done_o | output | 1 | One-cycle pulse closing the row set |

## Verification
Several properties are checked on every cycle: a stalled command holds still, indices stay in range for their mode, commands within a row set keep one mode and climb in index, single-bank commands never carry the fine flag, and done is a lone pulse apart from any command. Only the bench scenarios can show that the chosen mode is the cheapest for a given mask and that the command set covers exactly the weak banks. The same holds for an empty mask producing nothing but done, and for a mask offered mid-sequence being discarded.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    RM_ALL  = 2'b00,
    RM_HALF = 2'b01,
    RM_QUAD = 2'b10,
    RM_BANK = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_PICK  = 2'b01,
    SQ_ISSUE = 2'b10,
    SQ_FIN   = 2'b11
  } seq_state_e;

endpackage

// File: rtl/rfs_group_occ.sv
// Reduces a bank mask to one occupancy bit per group of GSIZE adjacent banks.
module rfs_group_occ #(
  parameter int NBANK = 8,
  parameter int GSIZE = 4
) (
  input  logic [NBANK-1:0]       bank_mask_i,
  output logic [NBANK/GSIZE-1:0] occ_o
);
  localparam int NGRP = NBANK / GSIZE;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign occ_o[g] = |bank_mask_i[g*GSIZE +: GSIZE];
  end
endmodule

// File: rtl/rfs_cost_pick.sv
// Weighs the four granularities over the weak-bank mask and picks the cheapest.
module rfs_cost_pick
  import rfs_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int W_ALL  = 1000,
  parameter int W_HALF = 758,
  parameter int W_QUAD = 575,
  parameter int W_BANK = 435
) (
  input  logic [NBANK-1:0] bank_mask_i,
  output rmode_e           mode_o,
  output logic [NBANK-1:0] units_o
);
  localparam int NHALF = 2;
  localparam int NQUAD = 4;
  localparam int WSUM  = W_ALL + W_HALF + W_QUAD + W_BANK;
  localparam int CW    = $clog2(NBANK * WSUM + 1);
  localparam int NW    = $clog2(NBANK + 1);

  logic [0:0]       occ_all;
  logic [NHALF-1:0] occ_half;
  logic [NQUAD-1:0] occ_quad;

  rfs_group_occ #(.NBANK(NBANK), .GSIZE(NBANK))       u_occ_all  (.bank_mask_i(bank_mask_i), .occ_o(occ_all));
  rfs_group_occ #(.NBANK(NBANK), .GSIZE(NBANK/NHALF)) u_occ_half (.bank_mask_i(bank_mask_i), .occ_o(occ_half));
  rfs_group_occ #(.NBANK(NBANK), .GSIZE(NBANK/NQUAD)) u_occ_quad (.bank_mask_i(bank_mask_i), .occ_o(occ_quad));

  logic [NW-1:0] n_all, n_half, n_quad, n_bank;
  logic [CW-1:0] c_all, c_half, c_quad, c_bank, c_best;

  always_comb begin
    n_all  = NW'(occ_all[0]);
    n_half = '0;
    n_quad = '0;
    n_bank = '0;
    for (int i = 0; i < NHALF; i++) n_half = n_half + NW'(occ_half[i]);
    for (int i = 0; i < NQUAD; i++) n_quad = n_quad + NW'(occ_quad[i]);
    for (int i = 0; i < NBANK; i++) n_bank = n_bank + NW'(bank_mask_i[i]);
  end

  assign c_all  = CW'(n_all)  * CW'(W_ALL);
  assign c_half = CW'(n_half) * CW'(W_HALF);
  assign c_quad = CW'(n_quad) * CW'(W_QUAD);
  assign c_bank = CW'(n_bank) * CW'(W_BANK);

  // Coarse to fine with strict less-than: a tie keeps the coarser mode.
  always_comb begin
    mode_o = RM_ALL;
    c_best = c_all;
    if (c_half < c_best) begin mode_o = RM_HALF; c_best = c_half; end
    if (c_quad < c_best) begin mode_o = RM_QUAD; c_best = c_quad; end
    if (c_bank < c_best) begin mode_o = RM_BANK; c_best = c_bank; end
  end

  always_comb begin
    units_o = '0;
    unique case (mode_o)
      RM_ALL:  units_o[0]         = occ_all[0];
      RM_HALF: units_o[NHALF-1:0] = occ_half;
      RM_QUAD: units_o[NQUAD-1:0] = occ_quad;
      default: units_o            = bank_mask_i;
    endcase
  end
endmodule

// File: rtl/rfs_cmd_seq.sv
// Captures a row set, latches the chosen mode and emits one command per unit.
module rfs_cmd_seq
  import rfs_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int SW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBANK-1:0] mask_i,
  input  logic             fine_i,
  output logic [NBANK-1:0] mask_q_o,
  input  rmode_e           pick_mode_i,
  input  logic [NBANK-1:0] pick_units_i,
  output logic             valid_o,
  input  logic             ready_i,
  output rmode_e           mode_o,
  output logic [SW-1:0]    sel_o,
  output logic             fine_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  logic [NBANK-1:0] mask_q;
  logic             fine_q;
  rmode_e           mode_q;
  logic [NBANK-1:0] pend_q, pend_d;
  logic             cap_en, pick_en, pend_en;
  logic [SW-1:0]    low_idx;
  logic [NBANK-1:0] low_bit;

  always_comb begin
    low_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (pend_q[i]) low_idx = SW'(i);
    end
    low_bit = '0;
    low_bit[low_idx] = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cap_en  = 1'b0;
    pick_en = 1'b0;
    pend_en = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start_i) begin
        cap_en  = 1'b1;
        state_d = SQ_PICK;
      end
      SQ_PICK: begin
        pick_en = 1'b1;
        pend_en = 1'b1;
        pend_d  = pick_units_i;
        state_d = (pick_units_i == '0) ? SQ_FIN : SQ_ISSUE;
      end
      SQ_ISSUE: if (ready_i) begin
        pend_en = 1'b1;
        pend_d  = pend_q & ~low_bit;
        if ((pend_q & ~low_bit) == '0) state_d = SQ_FIN;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      fine_q <= 1'b0;
    end else if (cap_en) begin
      mask_q <= mask_i;
      fine_q <= fine_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RM_ALL;
    else if (pick_en) mode_q <= pick_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign mask_q_o = mask_q;
  assign valid_o  = (state_q == SQ_ISSUE);
  assign done_o   = (state_q == SQ_FIN);
  assign mode_o   = mode_q;
  assign sel_o    = low_idx;
  assign fine_o   = fine_q && (mode_q != RM_BANK);
endmodule

// File: rtl/rfs_rst_sync.sv
// Asynchronous assertion, synchronous release.
module rfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rfs_mode_select.sv
module rfs_mode_select
  import rfs_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int W_ALL  = 1000,
  parameter int W_HALF = 758,
  parameter int W_QUAD = 575,
  parameter int W_BANK = 435,
  localparam int SW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBANK-1:0] weak_mask_i,
  input  logic             fine_gran_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [1:0]       cmd_mode_o,
  output logic [SW-1:0]    cmd_sel_o,
  output logic             cmd_fine_o,
  output logic             done_o
);
  logic             rst_sync_n;
  logic [NBANK-1:0] mask_q;
  rmode_e           pick_mode;
  logic [NBANK-1:0] pick_units;
  rmode_e           seq_mode;

  rfs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rfs_cost_pick #(
    .NBANK(NBANK), .W_ALL(W_ALL), .W_HALF(W_HALF), .W_QUAD(W_QUAD), .W_BANK(W_BANK)
  ) u_pick (
    .bank_mask_i(mask_q), .mode_o(pick_mode), .units_o(pick_units)
  );

  rfs_cmd_seq #(.NBANK(NBANK)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(start_i), .mask_i(weak_mask_i), .fine_i(fine_gran_i),
    .mask_q_o(mask_q), .pick_mode_i(pick_mode), .pick_units_i(pick_units),
    .valid_o(cmd_valid_o), .ready_i(cmd_ready_i),
    .mode_o(seq_mode), .sel_o(cmd_sel_o), .fine_o(cmd_fine_o), .done_o(done_o)
  );

  assign cmd_mode_o = seq_mode;
endmodule

// File: rtl/rfs_mode_select_chk.sv
module rfs_mode_select_chk #(
  parameter int NBANK = 8,
  localparam int SW   = $clog2(NBANK)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [1:0]    cmd_mode_o,
  input logic [SW-1:0] cmd_sel_o,
  input logic          cmd_fine_o,
  input logic          done_o
);
  logic          have_q;
  logic [SW-1:0] last_sel_q;
  logic [1:0]    last_mode_q;
  logic          fire;

  assign fire = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q      <= 1'b0;
      last_sel_q  <= '0;
      last_mode_q <= '0;
    end else if (fire) begin
      have_q      <= 1'b1;
      last_sel_q  <= cmd_sel_o;
      last_mode_q <= cmd_mode_o;
    end else if (done_o) begin
      have_q <= 1'b0;
    end
  end

  // R6: a stalled command holds
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_mode_o) && $stable(cmd_sel_o));

  // R7: done is a lone pulse, never with a command
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o);

  // R9: single-bank commands never carry the fine flag
  p_no_fine_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && (cmd_mode_o == 2'b11) |-> !cmd_fine_o);

  // R3: index within range of its mode
  p_sel_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ((cmd_mode_o == 2'b00) && (cmd_sel_o == '0)) ||
                    ((cmd_mode_o == 2'b01) && (cmd_sel_o < SW'(2))) ||
                    ((cmd_mode_o == 2'b10) && (cmd_sel_o < SW'(4))) ||
                    (cmd_mode_o == 2'b11));

  // R4: ascending order, one mode per row set
  p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && have_q |-> (cmd_sel_o > last_sel_q) && (cmd_mode_o == last_mode_q));
endmodule

bind rfs_mode_select rfs_mode_select_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_mode_o(cmd_mode_o), .cmd_sel_o(cmd_sel_o),
  .cmd_fine_o(cmd_fine_o), .done_o(done_o)
);

// File: tb/tb_rfs_mode_select.sv
`timescale 1ns/1ps
module tb_rfs_mode_select;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] weak_mask_i;
  logic       fine_gran_i;
  logic       cmd_valid_o;
  logic       cmd_ready_i;
  logic [1:0] cmd_mode_o;
  logic [2:0] cmd_sel_o;
  logic       cmd_fine_o;
  logic       done_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  rfs_mode_select dut (.*);

  typedef struct packed {
    logic [7:0] m;
    logic [1:0] md;
    logic [3:0] n;
    logic [2:0] s;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{8'h01, 2'd3, 4'd1, 3'd0}, '{8'h03, 2'd2, 4'd1, 3'd0},
    '{8'h07, 2'd1, 4'd1, 3'd0}, '{8'h1F, 2'd0, 4'd1, 3'd0},
    '{8'h81, 2'd3, 4'd2, 3'd0}, '{8'h05, 2'd1, 4'd1, 3'd0},
    '{8'h30, 2'd2, 4'd1, 3'd2}, '{8'hC3, 2'd0, 4'd1, 3'd0},
    '{8'h41, 2'd3, 4'd2, 3'd0}, '{8'h11, 2'd3, 4'd2, 3'd0},
    '{8'h33, 2'd0, 4'd1, 3'd0}, '{8'h0F, 2'd1, 4'd1, 3'd0},
    '{8'hF0, 2'd1, 4'd1, 3'd1}, '{8'h15, 2'd0, 4'd1, 3'd0},
    '{8'h24, 2'd3, 4'd2, 3'd2}, '{8'h0C, 2'd2, 4'd1, 3'd1},
    '{8'h40, 2'd3, 4'd1, 3'd6}, '{8'h3C, 2'd0, 4'd1, 3'd0},
    '{8'h06, 2'd1, 4'd1, 3'd0}, '{8'hFF, 2'd0, 4'd1, 3'd0},
    '{8'hC0, 2'd2, 4'd1, 3'd3}, '{8'h60, 2'd1, 4'd1, 3'd1}
  };

  logic [1:0] q_mode [16];
  logic [2:0] q_sel  [16];
  logic       q_fine [16];
  int         ncmd;
  bit         saw_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cover_of(input logic [1:0] md, input logic [2:0] s);
    case (md)
      2'd0:    return 8'hFF;
      2'd1:    return 8'h0F << (4 * s);
      2'd2:    return 8'h03 << (2 * s);
      default: return 8'h01 << s;
    endcase
  endfunction

  task automatic offer(input logic [7:0] m, input logic f);
    @(negedge clk);
    start_i = 1'b1; weak_mask_i = m; fine_gran_i = f;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic collect();
    ncmd = 0; saw_done = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (done_o) begin saw_done = 1'b1; break; end
      if (cmd_valid_o && cmd_ready_i && ncmd < 16) begin
        q_mode[ncmd] = cmd_mode_o; q_sel[ncmd] = cmd_sel_o; q_fine[ncmd] = cmd_fine_o;
        ncmd++;
      end
      @(negedge clk);
    end
    chk(saw_done, "R7 done seen", int'(saw_done), 1);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", int'(done_o), 0);
  endtask

  task automatic check_set(input logic [7:0] m, input vec_t v);
    logic [7:0] uni = '0;
    bit asc = 1'b1, each = 1'b1, same = 1'b1;
    chk(ncmd == int'(v.n), "R4 command count", ncmd, int'(v.n));
    if (ncmd > 0) begin
      chk(q_mode[0] == v.md, "R2 chosen mode", int'(q_mode[0]), int'(v.md));
      chk(q_sel[0] == v.s, "R3 first index", int'(q_sel[0]), int'(v.s));
    end
    for (int k = 0; k < ncmd; k++) begin
      uni = uni | cover_of(q_mode[k], q_sel[k]);
      if ((cover_of(q_mode[k], q_sel[k]) & m) == 8'h00) each = 1'b0;
      if (k > 0 && q_sel[k] <= q_sel[k-1]) asc = 1'b0;
      if (k > 0 && q_mode[k] != q_mode[0]) same = 1'b0;
    end
    chk((uni & m) == m, "R4 all weak banks covered", int'(uni), int'(m));
    chk(each && asc && same, "R4 useful ascending one-mode", {each, asc, same}, 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; weak_mask_i = '0; fine_gran_i = 1'b0; cmd_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !done_o, "R1 outputs in reset", {cmd_valid_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmd_valid_o && !done_o, "R1 outputs idle after reset", {cmd_valid_o, done_o}, 0);

    // Table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      offer(VT[i].m, 1'b0);
      collect();
      check_set(VT[i].m, VT[i]);
    end

    // R5: empty mask
    offer(8'h00, 1'b0);
    collect();
    chk(ncmd == 0, "R5 no command for empty mask", ncmd, 0);

    // R9: fine flag follows request, dropped for single-bank
    offer(8'h0F, 1'b1);
    collect();
    chk(ncmd == 1 && q_fine[0], "R9 fine kept for half", int'(q_fine[0]), 1);
    offer(8'h01, 1'b1);
    collect();
    chk(ncmd == 1 && !q_fine[0], "R9 fine dropped for bank", int'(q_fine[0]), 0);
    offer(8'h03, 1'b0);
    collect();
    chk(ncmd == 1 && !q_fine[0], "R9 fine off when not asked", int'(q_fine[0]), 0);

    // R6 stall and R8 ignored start
    cmd_ready_i = 1'b0;
    offer(8'h81, 1'b0);
    @(negedge clk);
    chk(cmd_valid_o && cmd_sel_o == 3'd0 && cmd_mode_o == 2'd3, "R6 first command offered",
        {cmd_valid_o, cmd_mode_o, cmd_sel_o}, {1'b1, 2'd3, 3'd0});
    start_i = 1'b1; weak_mask_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(cmd_valid_o && cmd_sel_o == 3'd0 && cmd_mode_o == 2'd3, "R6 command held",
          {cmd_valid_o, cmd_mode_o, cmd_sel_o}, {1'b1, 2'd3, 3'd0});
      @(negedge clk);
    end
    cmd_ready_i = 1'b1;
    collect();
    chk(ncmd == 2 && q_sel[0] == 3'd0 && q_sel[1] == 3'd7 && q_mode[1] == 2'd3,
        "R8 late start ignored", ncmd, 2);
    for (int k = 0; k < 4; k++) begin
      chk(!cmd_valid_o && !done_o, "R8 no extra row set", {cmd_valid_o, done_o}, 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule